// File: doc/BRIEF.md
# Serial Register Readback Slave

This block is the serial slave that lets a host read back the register bank of a four-channel converter. The host sends 24-bit frames, most significant bit first, with chip-select held low. A frame whose top bit is set is a read request. It is honoured only when its 2-bit device field equals the strap pins. Its 5-bit selector picks one register. The register value does not come back in the same frame. It is captured when the request frame ends and shifted out on the serial output during the next complete frame, whatever that frame carries.

Serial pins are sampled by the system clock through synchroniser stages. Incoming bits are taken on serial clock rising edges. The output bit moves on falling edges, so the host always samples a settled value. A small test-load port fills the register storage. It has a valid/ready pair, and ready is held high, so the port never applies back-pressure: a write is taken in every cycle that valid is high. The serial output has its own enable pin, and a pad built from the two pins gives high impedance whenever the enable is low.

Top module: `spi_readback_slave`

## Requirements
- R1: A 24-bit frame is a read request when bit 23 is 1 and bits 22:21 equal `dev_addr_i`. Bits 20:16 hold the selector. Bits 15:0 are ignored.
- R2: After a valid read request, the next complete frame drives `spi_miso_oe_o` high for the whole frame. `spi_miso_o` carries a 24-bit word, MSB first: 8 zero bits, then the 16-bit register value. The output bit changes only after a serial clock falling edge.
- R3: Selector value 4*k + c reads channel c (A=0 to D=3) of bank k. The banks are numbered as follows: data 0, control 1, gain 2, offset 3, clear code 4, slew control 5. Selector 24 reads status, 25 reads main control and 26 reads converter-supply control.
- R4: Selectors 27 to 31 read back as zero, with the output enabled.
- R5: A read request whose device field differs from `dev_addr_i` is dropped. The output enable stays low through the next frame.
- R6: A complete frame with bit 23 clear still shifts out any pending readback. The frame after it has the output disabled.
- R7: A frame with a count of serial clocks other than 24 is discarded. The pending readback is kept and is returned in full by the next complete frame.
- R8: `spi_miso_oe_o` is low whenever chip-select is high, and also out of reset until a valid request has completed.
- R9: The test-load port has `tw_ready_o` always high. A write with `tw_sel_i` below 27 stores `tw_data_i`. A write to selector 27 to 31 has no effect.
- R10: The value returned is the one the register held when the request frame ended. Writes made after that do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 2 | Device address strap |
| spi_sclk_i | input | 1 | Serial clock |
| spi_cs_n_i | input | 1 | Active-low chip-select (frame sync) |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| spi_miso_oe_o | output | 1 | Output enable for serial data out |
| tw_valid_i | input | 1 | Test-load write valid |
| tw_ready_o | output | 1 | Test-load write ready (always high) |
| tw_sel_i | input | 5 | Test-load register selector |
| tw_data_i | input | 16 | Test-load register value |

## Verification
The hardest state to reach is a pending readback that survives an aborted frame. This needs a valid request, then a frame cut short or over-clocked, then a complete frame, all with the host-side model still expecting the captured value. The stimulus runs the serial master through frames of 10 and 26 clocks placed between requests. It also puts a test-load write between a request and its readback, which shows that capture happens when the request frame ends. A selector sweep, a write frame, an address mismatch and a strap change cover the remaining paths into and out of the pending state.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 2;
  localparam int SEL_W   = 5;
  localparam int REG_W   = 16;
  localparam int HDR_W   = 1 + ADDR_W + SEL_W;

  typedef struct packed {
    logic             valid;
    logic [REG_W-1:0] data;
  } readback_t;

  function automatic logic sel_implemented(input logic [SEL_W-1:0] sel, input int impl);
    return int'(sel) < impl;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic frame_start_o,
  output logic frame_end_o,
  output logic cs_active_o,
  output logic mosi_o
);
  // bit 2: sclk, bit 1: cs_n, bit 0: mosi
  logic [STAGES-1:0][2:0] stage_q;
  logic [1:0]             prev_q;
  logic                   sclk_s, cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= 3'b010;
      prev_q <= 2'b01;
    end else begin
      stage_q[0] <= {sclk_i, cs_n_i, mosi_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1][2:1];
    end
  end

  assign sclk_s        = stage_q[STAGES-1][2];
  assign cs_n_s        = stage_q[STAGES-1][1];
  assign mosi_o        = stage_q[STAGES-1][0];
  assign cs_active_o   = !cs_n_s;
  assign frame_start_o = prev_q[0] && !cs_n_s;
  assign frame_end_o   = !prev_q[0] && cs_n_s;
  assign sclk_rise_o   = !prev_q[1] && sclk_s && !cs_n_s;
  assign sclk_fall_o   = prev_q[1] && !sclk_s && !cs_n_s;
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FRAME_W = 24,
  parameter int HDR_W   = 8,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic               frame_end_i,
  input  logic               cs_active_i,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               mosi_i,
  input  logic               load_valid_i,
  input  logic [FRAME_W-1:0] load_word_i,
  output logic               frame_done_o,
  output logic [HDR_W-1:0]   header_o,
  output logic [CNT_W-1:0]   bit_cnt_o,
  output logic               miso_o,
  output logic               miso_oe_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               tx_en_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      tx_en_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_end_i && (cnt_q == CNT_FULL);
      if (frame_start_i) begin
        cnt_q   <= '0;
        tx_q    <= load_word_i;
        tx_en_q <= load_valid_i;
      end else begin
        if (sclk_rise_i) begin
          rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
          if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        if (frame_end_i) tx_en_q <= 1'b0;
      end
    end
  end

  assign frame_done_o = done_q;
  assign header_o     = rx_q[FRAME_W-1 -: HDR_W];
  assign bit_cnt_o    = cnt_q;
  assign miso_oe_o    = tx_en_q && cs_active_i;
  assign miso_o       = miso_oe_o && tx_q[FRAME_W-1];
endmodule

// File: rtl/spi_read_request.sv
module spi_read_request
  import spi_rb_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int ADDR_W  = 2,
  parameter int SEL_W   = 5,
  parameter int REG_W   = 16,
  localparam int HDR_W  = 1 + ADDR_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done_i,
  input  logic [HDR_W-1:0]   header_i,
  input  logic [ADDR_W-1:0]  strap_i,
  input  logic [REG_W-1:0]   rd_data_i,
  output logic [SEL_W-1:0]   rd_sel_o,
  output logic               pend_valid_o,
  output logic [REG_W-1:0]   pend_data_o,
  output logic [FRAME_W-1:0] load_word_o
);
  logic              is_read, addr_hit;
  logic [ADDR_W-1:0] dev_field;
  readback_t         pend_q;

  assign is_read   = header_i[HDR_W-1];
  assign dev_field = header_i[HDR_W-2 -: ADDR_W];
  assign rd_sel_o  = header_i[SEL_W-1:0];
  assign addr_hit  = (dev_field == strap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (frame_done_i) begin
      pend_q.valid <= is_read && addr_hit;
      pend_q.data  <= rd_data_i;
    end
  end

  assign pend_valid_o = pend_q.valid;
  assign pend_data_o  = pend_q.data;
  assign load_word_o  = {{(FRAME_W-REG_W){1'b0}}, pend_q.data};
endmodule

// File: rtl/readback_regbank.sv
module readback_regbank
  import spi_rb_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int BANKS    = 6,
  parameter int GLOBALS  = 3,
  parameter int SEL_W    = 5,
  parameter int REG_W    = 16,
  localparam int SLOTS   = 1 << SEL_W,
  localparam int IMPL    = CHANNELS * BANKS + GLOBALS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [SLOTS-1:0][REG_W-1:0] slot_w;
  logic                        wr_legal;

  assign wr_legal = wr_valid_i && sel_implemented(wr_sel_i, IMPL);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < IMPL) begin : g_store
        logic [REG_W-1:0] store_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) store_q <= '0;
          else if (wr_legal && (wr_sel_i == SEL_W'(g))) store_q <= wr_data_i;
        end
        assign slot_w[g] = store_q;
      end else begin : g_empty
        assign slot_w[g] = '0;
      end
    end
  endgenerate

  assign rd_data_o = slot_w[rd_sel_i];
endmodule

// File: rtl/spi_readback_slave.sv
module spi_readback_slave
  import spi_rb_pkg::*;
#(
  parameter int CHANNELS    = 4,
  parameter int BANKS       = 6,
  parameter int GLOBALS     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              tw_valid_i,
  output logic              tw_ready_o,
  input  logic [SEL_W-1:0]  tw_sel_i,
  input  logic [REG_W-1:0]  tw_data_i
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic               sclk_rise, sclk_fall, frame_start, frame_end, cs_active, mosi_s;
  logic               frame_done, pend_valid;
  logic [HDR_W-1:0]   header;
  logic [CNT_W-1:0]   bit_cnt;
  logic [SEL_W-1:0]   rd_sel;
  logic [REG_W-1:0]   rd_data, pend_data;
  logic [FRAME_W-1:0] load_word;

  assign tw_ready_o = 1'b1;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(spi_sclk_i), .cs_n_i(spi_cs_n_i), .mosi_i(spi_mosi_i),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .frame_start_o(frame_start), .frame_end_o(frame_end),
    .cs_active_o(cs_active), .mosi_o(mosi_s)
  );

  spi_frame_shifter #(.FRAME_W(FRAME_W), .HDR_W(HDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(frame_start), .frame_end_i(frame_end), .cs_active_i(cs_active),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .mosi_i(mosi_s),
    .load_valid_i(pend_valid), .load_word_i(load_word),
    .frame_done_o(frame_done), .header_o(header), .bit_cnt_o(bit_cnt),
    .miso_o(spi_miso_o), .miso_oe_o(spi_miso_oe_o)
  );

  spi_read_request #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .REG_W(REG_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .frame_done_i(frame_done), .header_i(header), .strap_i(dev_addr_i),
    .rd_data_i(rd_data), .rd_sel_o(rd_sel),
    .pend_valid_o(pend_valid), .pend_data_o(pend_data), .load_word_o(load_word)
  );

  readback_regbank #(.CHANNELS(CHANNELS), .BANKS(BANKS), .GLOBALS(GLOBALS),
                     .SEL_W(SEL_W), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_valid_i(tw_valid_i), .wr_sel_i(tw_sel_i), .wr_data_i(tw_data_i),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );
endmodule

// File: rtl/spi_readback_checker.sv
module spi_readback_checker
  import spi_rb_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              sclk_fall,
  input logic              frame_end,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [HDR_W-1:0]  header,
  input logic [ADDR_W-1:0] dev_addr_i,
  input logic              pend_valid,
  input logic [REG_W-1:0]  pend_data,
  input logic              spi_miso_o,
  input logic              spi_miso_oe_o
);
  p_hit_sets_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && header[HDR_W-1] && header[HDR_W-2 -: ADDR_W] == dev_addr_i) |=> pend_valid);

  p_first_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe_o) |-> !spi_miso_o);

  p_change_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe_o && $past(spi_miso_oe_o) && spi_miso_o != $past(spi_miso_o)) |-> $past(sclk_fall));

  p_miss_clears_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (!header[HDR_W-1] || header[HDR_W-2 -: ADDR_W] != dev_addr_i)) |=> !pend_valid);

  p_abort_keeps_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && bit_cnt != CNT_W'(FRAME_W)) |-> ##2 ($stable(pend_valid) && $stable(pend_data)));

  p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W + 1));

  p_oe_only_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !spi_miso_oe_o);
endmodule

bind spi_readback_slave spi_readback_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_fall(sclk_fall),
  .frame_end(frame_end), .frame_done(frame_done), .bit_cnt(bit_cnt), .header(header),
  .dev_addr_i(dev_addr_i), .pend_valid(pend_valid), .pend_data(pend_data),
  .spi_miso_o(spi_miso_o), .spi_miso_oe_o(spi_miso_oe_o)
);

// File: tb/spi_readback_slave_bench.sv
`timescale 1ns/1ps
module spi_readback_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap = 2'd1;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, tw_valid = 1'b0, tw_ready;
  logic [4:0]  tw_sel = '0;
  logic [15:0] tw_data = '0;

  int checks = 0, failures = 0;
  bit idle_chk = 1'b0;

  // behavioural reference state
  int unsigned ref_reg [32];
  bit          ref_pend_v = 1'b0;
  int unsigned ref_pend_d = 0;

  always #2 clk = ~clk;

  spi_readback_slave u_spi_readback_slave (
    .clk(clk), .rst_n(rst_n), .dev_addr_i(strap),
    .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .tw_valid_i(tw_valid), .tw_ready_o(tw_ready), .tw_sel_i(tw_sel), .tw_data_i(tw_data)
  );

  // R8: output must stay disabled on every clock while the frame is closed
  always @(negedge clk) begin
    if (idle_chk && rst_n) begin
      checks++;
      if (miso_oe !== 1'b0) begin
        failures++;
        $display("FAIL R8 idle oe actual=%b expected=0", miso_oe);
      end
    end
  end

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tload(input int sel, input int unsigned val);
    @(negedge clk);
    tw_valid = 1'b1; tw_sel = 5'(sel); tw_data = 16'(val);
    @(negedge clk);
    tw_valid = 1'b0;
    if (sel < 27) ref_reg[sel] = val & 16'hFFFF;
  endtask

  task automatic xfer(input logic [23:0] word, input int nclk, input string tag);
    bit          exp_oe;
    int unsigned exp_w, got, oe_bad;
    exp_oe = ref_pend_v;
    exp_w  = ref_pend_d & 16'hFFFF;
    got = 0; oe_bad = 0;
    idle_chk = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 24) ? word[23-i] : 1'b0;
      repeat (8) @(negedge clk);
      if (miso_oe !== exp_oe) oe_bad++;
      if (i < 24 && miso === 1'b1) got = got | (32'd1 << (23 - i));
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    idle_chk = 1'b1;
    check({tag, " oe mismatches"}, oe_bad, 0);
    if (exp_oe && nclk >= 24) check({tag, " data"}, got, exp_w);
    if (nclk == 24) begin
      ref_pend_v = word[23] && (word[22:21] == strap);
      ref_pend_d = (int'(word[20:16]) < 27) ? ref_reg[word[20:16]] : 0;
    end
  endtask

  function automatic logic [23:0] rd(input int dev, input int sel);
    return {1'b1, 2'(dev), 5'(sel), 16'hFFFF};
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) ref_reg[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 reset oe", miso_oe, 0);
    check("R9 ready", tw_ready, 1);
    idle_chk = 1'b1;

    // R9: fill every selector; 27..31 must not store
    for (int s = 0; s < 32; s++) tload(s, (s * 16'h0B17) ^ 16'hA5C3);

    xfer(24'h000000, 24, "R8 no pending after reset");
    xfer(24'hA80000, 24, "R1 write-only first");     // read dev1 gain A
    xfer(rd(1, 0), 24, "R3 gain A returned");
    for (int s = 1; s < 32; s++) xfer(rd(1, s), 24, "R3 R4 sweep");
    xfer(24'h7FFFFF, 24, "R6 write frame returns pending");
    xfer(24'h000000, 24, "R6 after write frame");

    xfer(rd(2, 8), 24, "R5 mismatched request");
    xfer(rd(1, 9), 24, "R5 no output after mismatch");
    xfer(rd(1, 24), 24, "R1 returns gain B");

    xfer(rd(1, 25), 10, "R7 short frame");
    xfer(rd(1, 25), 26, "R7 long frame");
    xfer(24'h000000, 24, "R7 pending kept");

    xfer(rd(1, 2), 24, "R10 request");
    tload(2, 16'h1234);
    xfer(rd(1, 2), 24, "R10 old value");
    xfer(24'h000000, 24, "R10 new value");

    tload(30, 16'hBEEF);
    xfer(rd(1, 30), 24, "R9 request empty slot");
    xfer(24'h000000, 24, "R9 R4 empty slot zero");

    strap = 2'd3;
    repeat (4) @(negedge clk);
    xfer(rd(1, 26), 24, "R5 old strap");
    xfer(rd(3, 26), 24, "R5 no output");
    xfer(24'h000000, 24, "R3 supply control");

    idle_chk = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule